// File: doc/BRIEF.md
# Clock Configuration Serial Target

This block is the two-wire (I2C, standard mode) configuration target of a system clock generator. It holds the enable masks for the generator's output clocks and a control byte with a 5-bit frequency-select field, a spread-spectrum enable, a source-select bit and an SDRAM feedback-clock enable. A host programs it with block writes and checks it with block reads. Neither kind of transfer carries a register address: a write always begins with two throw-away bytes and then fills register bytes in ascending order starting at byte 0. A read always begins with a byte count.

While reset is held, the block samples a 5-bit strap bus on every clock. The value present when reset is released stays latched, and the block then raises a flag that tells the pads to turn the strap pins into outputs. The frequency select and spread enable sent to the clock datapath come either from the latched straps and an active-low spread pin, or from the programmed control byte. The source-select bit in that byte makes the choice.

SCL and SDA are sampled by the block's own clock through synchronizers. SDA is modelled as an open-drain pad: the output is always low and only its enable is driven. The block never stretches the clock.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The target acknowledges the address bytes 0xD2 (write) and 0xD3 (read). It does not acknowledge any other address byte, and a transfer to another address changes no register.
- R2: In a write, the two bytes after the address are acknowledged and discarded. The following data bytes are acknowledged and stored as bytes 0, 1, 2 and so on, in that order. Byte 4 is the first output-enable mask (en_a_o), byte 5 is the second mask (en_b_o), byte 6 is the control byte, and bytes 0 to 3 are accepted but not stored.
- R3: A STOP after any complete byte ends the write. Bytes already received keep their new values, and later bytes keep their old values.
- R4: Data bytes past byte 6 are acknowledged and have no effect on any register.
- R5: A read returns the count 0x06, then bytes 0 to 5 in order, with bytes 0 to 3 reading 0x00. Any byte requested beyond these reads 0x00.
- R6: If the host does not acknowledge a read byte, the target releases SDA and ignores the bus until the next START. Bits clocked during that time read 1.
- R7: A repeated START at any point restarts the address phase.
- R8: Reset sets both enable masks to 0xFF and the control byte to 0x01: SDRAM clock enabled, spread bit 0, source select 0, programmed select 00000.
- R9: strap_i is sampled while rst_n is low and held once rst_n is high, whatever strap_i does afterwards. out_mode_o is 0 during reset and 1 after it.
- R10: When control bit 1 is 0, fsel_o equals the latched straps and spread_en_o equals the inverse of spread_pin_n_i. When control bit 1 is 1, fsel_o equals control bits 6:2 and spread_en_o equals control bit 7. sdram_en_o always equals control bit 0.
- R11: The target turns its SDA drive on only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data from the pad |
| sda_o | output | 1 | Serial data output value, always 0 (open drain) |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| strap_i | input | 5 | Frequency-select strap levels |
| spread_pin_n_i | input | 1 | Active-low spread-spectrum pin |
| en_a_o | output | 8 | Output-enable mask, register byte 4 |
| en_b_o | output | 8 | Output-enable mask, register byte 5 |
| fsel_o | output | 5 | Frequency select sent to the synthesizer |
| spread_en_o | output | 1 | Spread-spectrum enable sent to the synthesizer |
| sdram_en_o | output | 1 | SDRAM feedback clock enable |
| out_mode_o | output | 1 | 1 once the strap pins may act as outputs |

## Verification
A table of four full block writes drives the control byte through both source settings. It uses pairs of values in which the register path and the pin path would give different frequency-select and spread results, so a swapped source is caught. Each write is followed by a full read-back.

Directed transfers cover the remaining cases:
- a foreign address;
- a write cut off after byte 4;
- a write that runs past byte 6;
- repeated STARTs in both directions;
- a read that the host NACKs early;
- a read that runs past the last byte.

Each of these shows whether the byte sequencing lines up with the throw-away bytes and the count byte, or is shifted by one.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned FSEL_W    = 5;
   localparam int unsigned MASK_A_IX = 4;
   localparam int unsigned MASK_B_IX = 5;
   localparam int unsigned CTRL_IX   = 6;
   localparam logic [BYTE_W-1:0] CTRL_RST = 8'h01;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_ACK_TX, ST_WR_BYTE, ST_RD_BYTE, ST_RD_ACK, ST_RD_LOAD
   } srl_state_e;
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clkcfg_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/clkcfg_serial_fsm.sv
module clkcfg_serial_fsm
   import clkcfg_pkg::*;
#(
   parameter logic [6:0]  TGT_ADDR = 7'h69,
   parameter int unsigned IDX_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_stb,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sda_oe_o
);
   localparam int unsigned SKIP = 2;

   srl_state_e        state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic              rw;

   wire byte_done = scl_fall && (bitcnt == 4'd8);

   assign rd_idx  = idx;
   assign wr_stb  = (state == ST_WR_BYTE) && byte_done && (idx >= IDX_W'(SKIP));
   assign wr_idx  = idx - IDX_W'(SKIP);
   assign wr_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         idx      <= '0;
         rw       <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_det) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         idx      <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         sda_oe_o <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_WR_BYTE: begin
               if (scl_rise && bitcnt < 4'd8) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end
               if (byte_done) begin
                  if (state == ST_WR_BYTE) begin
                     sda_oe_o <= 1'b1;
                     state    <= ST_ACK_TX;
                     if (idx != '1) idx <= idx + 1'b1;
                  end else if (shreg[7:1] == TGT_ADDR) begin
                     rw       <= shreg[0];
                     sda_oe_o <= 1'b1;
                     state    <= ST_ACK_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ACK_TX: if (scl_fall) begin
               bitcnt <= '0;
               if (rw) begin
                  shreg    <= rd_data;
                  sda_oe_o <= ~rd_data[BYTE_W-1];
                  state    <= ST_RD_BYTE;
               end else begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_WR_BYTE;
               end
            end
            ST_RD_BYTE: begin
               if (scl_rise && bitcnt < 4'd8) bitcnt <= bitcnt + 4'd1;
               if (byte_done) begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_RD_ACK;
                  if (idx != '1) idx <= idx + 1'b1;
               end else if (scl_fall) begin
                  shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                  sda_oe_o <= ~shreg[BYTE_W-2];
               end
            end
            ST_RD_ACK: if (scl_rise) state <= sda_s ? ST_IDLE : ST_RD_LOAD;
            ST_RD_LOAD: if (scl_fall) begin
               bitcnt   <= '0;
               shreg    <= rd_data;
               sda_oe_o <= ~rd_data[BYTE_W-1];
               state    <= ST_RD_BYTE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
   import clkcfg_pkg::*;
#(
   parameter int unsigned RD_COUNT = 6,
   parameter int unsigned IDX_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FSEL_W-1:0] strap_i,
   input  logic              spread_pin_n_i,
   input  logic              wr_stb,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] en_a_o,
   output logic [BYTE_W-1:0] en_b_o,
   output logic [FSEL_W-1:0] fsel_o,
   output logic              spread_en_o,
   output logic              sdram_en_o,
   output logic              out_mode_o
);
   logic [BYTE_W-1:0] ctrl_q;
   logic [FSEL_W-1:0] strap_q;

   // Strap capture: follows the pins only while reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a_o     <= '1;
         en_b_o     <= '1;
         ctrl_q     <= CTRL_RST;
         out_mode_o <= 1'b0;
      end else begin
         out_mode_o <= 1'b1;
         if (wr_stb) begin
            if (wr_idx == IDX_W'(MASK_A_IX)) en_a_o <= wr_data;
            if (wr_idx == IDX_W'(MASK_B_IX)) en_b_o <= wr_data;
            if (wr_idx == IDX_W'(CTRL_IX))   ctrl_q <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx == '0)
         rd_data = 8'(RD_COUNT);
      else if (rd_idx <= IDX_W'(RD_COUNT)) begin
         if (rd_idx == IDX_W'(MASK_A_IX + 1)) rd_data = en_a_o;
         if (rd_idx == IDX_W'(MASK_B_IX + 1)) rd_data = en_b_o;
         if (rd_idx == IDX_W'(CTRL_IX + 1))   rd_data = ctrl_q;
      end
   end

   assign fsel_o      = ctrl_q[1] ? ctrl_q[6:2] : strap_q;
   assign spread_en_o = ctrl_q[1] ? ctrl_q[7]   : ~spread_pin_n_i;
   assign sdram_en_o  = ctrl_q[0];
endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
   import clkcfg_pkg::*;
#(
   parameter logic [6:0]  TGT_ADDR    = 7'h69,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RD_COUNT    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              sda_oe_o,
   input  logic [FSEL_W-1:0] strap_i,
   input  logic              spread_pin_n_i,
   output logic [BYTE_W-1:0] en_a_o,
   output logic [BYTE_W-1:0] en_b_o,
   output logic [FSEL_W-1:0] fsel_o,
   output logic              spread_en_o,
   output logic              sdram_en_o,
   output logic              out_mode_o
);
   localparam int unsigned IDX_W = $clog2(CTRL_IX + 4) + 1;

   if (RD_COUNT < 1 || RD_COUNT > CTRL_IX + 1) begin : g_bad_count
      $error("clkcfg_i2c_target: RD_COUNT out of range");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic wr_stb;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [BYTE_W-1:0] wr_data, rd_data;

   assign sda_o = 1'b0;

   clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   clkcfg_serial_fsm #(.TGT_ADDR(TGT_ADDR), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .rd_idx(rd_idx), .wr_stb(wr_stb), .wr_idx(wr_idx),
      .wr_data(wr_data), .sda_oe_o(sda_oe_o));

   clkcfg_regfile #(.RD_COUNT(RD_COUNT), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .spread_pin_n_i(spread_pin_n_i),
      .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
      .rd_data(rd_data), .en_a_o(en_a_o), .en_b_o(en_b_o), .fsel_o(fsel_o),
      .spread_en_o(spread_en_o), .sdram_en_o(sdram_en_o), .out_mode_o(out_mode_o));
endmodule

// File: rtl/clkcfg_i2c_target_chk.sv
module clkcfg_i2c_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_oe_o,
   input logic       scl_s,
   input logic       start_det,
   input logic       stop_det,
   input logic       wr_stb,
   input logic [7:0] en_a_o,
   input logic [7:0] en_b_o,
   input logic       out_mode_o
);
   // R11
   sda_drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);

   // R7
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe_o);

   // R3
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(en_a_o) && $stable(en_b_o)));

   // R9
   out_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_mode_o |=> out_mode_o);
endmodule

bind clkcfg_i2c_target clkcfg_i2c_target_chk u_chk (.*);

// File: tb/clkcfg_i2c_target_bench.sv
module clkcfg_i2c_target_bench;
   localparam int Q = 8;
   localparam logic [4:0] STRAP_V = 5'b10110;
   // {byte4, byte5, byte6}
   localparam logic [23:0] VEC [4] = '{
      {8'h5A, 8'hC3, 8'hD6},
      {8'h00, 8'hFF, 8'h33},
      {8'hF0, 8'h0F, 8'h7D},
      {8'h81, 8'h7E, 8'h0E}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_sda = 1'b1;
   logic [4:0] strap = STRAP_V;
   logic spread_n = 1'b1;
   logic sda_o, sda_oe;
   logic [7:0] en_a, en_b;
   logic [4:0] fsel;
   logic spread_en, sdram_en, out_mode;
   wire  sda_bus = host_sda & ~sda_oe;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [12];

   always #2.5 clk = ~clk;

   clkcfg_i2c_target u_clkcfg_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_o(sda_o),
      .sda_oe_o(sda_oe), .strap_i(strap), .spread_pin_n_i(spread_n),
      .en_a_o(en_a), .en_b_o(en_b), .fsel_o(fsel), .spread_en_o(spread_en),
      .sdram_en_o(sdram_en), .out_mode_o(out_mode));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wq;
      repeat (Q) @(negedge clk);
   endtask

   task automatic host_start;
      host_sda = 1'b1; scl = 1'b1; wq;
      host_sda = 1'b0; wq;
      scl = 1'b0;
   endtask

   task automatic host_rstart;
      wq; host_sda = 1'b1; wq;
      scl = 1'b1; wq;
      host_sda = 1'b0; wq;
      scl = 1'b0;
   endtask

   task automatic host_stop;
      wq; host_sda = 1'b0; wq;
      scl = 1'b1; wq;
      host_sda = 1'b1; wq;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         wq; host_sda = b[i]; wq;
         scl = 1'b1; wq; wq;
         scl = 1'b0;
      end
      wq; host_sda = 1'b1; wq;
      scl = 1'b1; wq;
      ack = (sda_bus == 1'b0);
      wq; scl = 1'b0;
   endtask

   task automatic recv_byte(input logic ack_it, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         wq; host_sda = 1'b1; wq;
         scl = 1'b1; wq;
         b[i] = sda_bus;
         wq; scl = 1'b0;
      end
      wq; host_sda = ack_it ? 1'b0 : 1'b1; wq;
      scl = 1'b1; wq; wq;
      scl = 1'b0;
      wq; host_sda = 1'b1;
   endtask

   // Sends addr then wbuf[0..n-1]; returns number of acknowledged bytes.
   task automatic wr_frame(input logic [7:0] addr, input int n, output int acks);
      logic a;
      acks = 0;
      host_start;
      send_byte(addr, a); if (a) acks++;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], a); if (a) acks++;
      end
      host_stop;
   endtask

   task automatic rd_frame(input int n, output logic addr_ack);
      host_start;
      send_byte(8'hD3, addr_ack);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      host_stop;
   endtask

   task automatic fill(input logic [7:0] b4, input logic [7:0] b5, input logic [7:0] b6);
      wbuf[0] = 8'h04; wbuf[1] = 8'hAA;
      wbuf[2] = 8'h11; wbuf[3] = 8'h22; wbuf[4] = 8'h33; wbuf[5] = 8'h44;
      wbuf[6] = b4; wbuf[7] = b5; wbuf[8] = b6;
   endtask

   task automatic check_read(input logic [7:0] b4, input logic [7:0] b5, input string tag);
      logic a;
      rd_frame(7, a);
      chk({tag, " read addr ack R1"}, {7'd0, a}, 8'h01);
      chk({tag, " count R5"}, rbuf[0], 8'h06);
      for (int i = 1; i <= 4; i++) chk({tag, " unused byte R5"}, rbuf[i], 8'h00);
      chk({tag, " byte4 R5"}, rbuf[5], b4);
      chk({tag, " byte5 R5"}, rbuf[6], b5);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int acks;
      logic a;
      logic [7:0] b;
      logic [7:0] b6;
      logic [4:0] exp_fs;
      logic exp_sp;

      repeat (10) @(negedge clk);
      chk("R9 out_mode in reset", {7'd0, out_mode}, 8'h00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      strap = 5'b01001;
      repeat (3) @(negedge clk);
      chk("R8 reset en_a", en_a, 8'hFF);
      chk("R8 reset en_b", en_b, 8'hFF);
      chk("R8 reset sdram_en", {7'd0, sdram_en}, 8'h01);
      chk("R9 strap held after reset", {3'd0, fsel}, {3'd0, STRAP_V});
      chk("R9 out_mode after reset", {7'd0, out_mode}, 8'h01);
      chk("R10 spread pin high", {7'd0, spread_en}, 8'h00);
      spread_n = 1'b0;
      @(negedge clk);
      chk("R10 spread pin low", {7'd0, spread_en}, 8'h01);
      check_read(8'hFF, 8'hFF, "R8 reset");

      // Table of full writes, then read-back.
      for (int v = 0; v < 4; v++) begin
         fill(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
         wr_frame(8'hD2, 9, acks);
         b6 = VEC[v][7:0];
         exp_fs = b6[1] ? b6[6:2] : STRAP_V;
         exp_sp = b6[1] ? b6[7] : ~spread_n;
         chk("R2 all bytes acked", 8'(acks), 8'd10);
         chk("R2 en_a", en_a, VEC[v][23:16]);
         chk("R2 en_b", en_b, VEC[v][15:8]);
         chk("R10 fsel", {3'd0, fsel}, {3'd0, exp_fs});
         chk("R10 spread_en", {7'd0, spread_en}, {7'd0, exp_sp});
         chk("R10 sdram_en", {7'd0, sdram_en}, {7'd0, b6[0]});
         check_read(VEC[v][23:16], VEC[v][15:8], "R2 table");
      end

      // R1: foreign address
      fill(8'h12, 8'h34, 8'h56);
      wr_frame(8'hA4, 9, acks);
      chk("R1 foreign address acks", 8'(acks), 8'd0);
      chk("R1 foreign en_a unchanged", en_a, 8'h81);
      chk("R1 foreign en_b unchanged", en_b, 8'h7E);

      // R3: stop after byte 4
      fill(8'h3C, 8'h99, 8'h02);
      wr_frame(8'hD2, 7, acks);
      chk("R3 partial en_a", en_a, 8'h3C);
      chk("R3 partial en_b kept", en_b, 8'h7E);
      chk("R3 partial fsel kept", {3'd0, fsel}, 8'h03);

      // R4: overlong write
      fill(8'h99, 8'h66, 8'h01);
      wbuf[9] = 8'hEE; wbuf[10] = 8'hDD; wbuf[11] = 8'hCC;
      wr_frame(8'hD2, 12, acks);
      chk("R4 overlong acks", 8'(acks), 8'd13);
      chk("R4 en_a", en_a, 8'h99);
      chk("R4 en_b", en_b, 8'h66);
      chk("R4 fsel back to strap", {3'd0, fsel}, {3'd0, STRAP_V});
      chk("R4 sdram_en", {7'd0, sdram_en}, 8'h01);

      // R7: repeated start inside a write
      host_start;
      send_byte(8'hD2, a);
      send_byte(8'h00, a); send_byte(8'h00, a);
      for (int i = 0; i < 4; i++) send_byte(8'h00, a);
      send_byte(8'h11, a);
      host_rstart;
      send_byte(8'hD2, a);
      chk("R7 re-address ack", {7'd0, a}, 8'h01);
      send_byte(8'h00, a); send_byte(8'h00, a);
      for (int i = 0; i < 4; i++) send_byte(8'h00, a);
      send_byte(8'h22, a);
      host_stop;
      chk("R7 en_a from second frame", en_a, 8'h22);
      chk("R7 en_b untouched", en_b, 8'h66);

      // R7: repeated start from write to read
      host_start;
      send_byte(8'hD2, a);
      send_byte(8'h00, a);
      host_rstart;
      send_byte(8'hD3, a);
      recv_byte(1'b0, b);
      host_stop;
      chk("R7 read after restart count", b, 8'h06);

      // R6: host NACK ends the read
      host_start;
      send_byte(8'hD3, a);
      recv_byte(1'b1, b);
      recv_byte(1'b0, b);
      chk("R6 byte0 before nack", b, 8'h00);
      recv_byte(1'b0, b);
      chk("R6 released after nack", b, 8'hFF);
      chk("R6 sda drive off", {7'd0, sda_oe}, 8'h00);
      host_stop;
      rd_frame(1, a);
      chk("R6 next start serves count", rbuf[0], 8'h06);

      // R5: read past the end
      rd_frame(10, a);
      chk("R5 count", rbuf[0], 8'h06);
      chk("R5 byte4", rbuf[5], 8'h22);
      chk("R5 byte5", rbuf[6], 8'h66);
      chk("R5 past end 1", rbuf[7], 8'h00);
      chk("R5 past end 2", rbuf[8], 8'h00);
      chk("R5 past end 3", rbuf[9], 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule